// File: doc/BRIEF.md
# Peripheral DMA Request Handshake Unit

This unit sits between sixteen peripheral request lines and a DMA transfer engine. Each line has four request inputs: burst, single, last burst and last single. The unit passes all four request vectors through a two-flop synchronizer. When it is idle, it picks the pending line with the lowest index. It turns that line's request into a beat count, which is the line's programmed burst size for a burst-type request or one for a single-type request. It also raises a flag when the request closes a packet.

While a grant is open, the engine reports each finished beat on `xfer_done`. When the beat that completes the count is reported, the unit sends a one-cycle clear pulse back on that line's bit of `clr` and closes the grant. The line stays locked out until its four synchronized request inputs have all gone low. This stops a request that is still held from being serviced a second time.

Top module: `dma_req_handshake`

## Requirements
- R1: A request driven on any input is seen through a two-flop synchronizer. From idle, `xfer_valid` rises on the third rising clock edge after the input changes, and not before.
- R2: If several lines are pending when the unit is idle, the grant goes to the lowest-index line, reported on `xfer_line`.
- R3: A burst or last-burst request sets `xfer_count` from the line's 2-bit field `burst_size[2i+1:2i]`. The code 0 gives 1 beat, 1 gives 4, 2 gives 8 and 3 gives 16.
- R4: A single or last-single request with no burst-type request on the same line gives `xfer_count` = 1.
- R5: If a burst-type request and a single-type request are both active on one line, the burst-type request decides the count and the last flag.
- R6: `xfer_last` is 1 when the winning request type is its "last" variant: last burst for a burst-type grant, last single for a single-type grant. Otherwise it is 0.
- R7: `clr` is a one-cycle pulse on the granted line's bit only. It is high in the cycle after the rising edge that accepts the final `xfer_done`, and `xfer_valid` falls on that same edge.
- R8: `xfer_done` has no effect when no grant is open. Before the final beat, it produces no `clr`.
- R9: After its clear pulse, a line is not granted again until all four of its synchronized request inputs have been low.
- R10: After reset, `xfer_valid` and `clr` are 0 and no line is locked out.
- R11: While a grant is open and has not completed, `xfer_line`, `xfer_count` and `xfer_last` stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_req | input | 16 | Burst request per line |
| single_req | input | 16 | Single request per line |
| last_burst_req | input | 16 | Last-burst request per line |
| last_single_req | input | 16 | Last-single request per line |
| burst_size | input | 32 | 2-bit burst size code per line |
| xfer_done | input | 1 | One beat of the open grant has finished |
| xfer_valid | output | 1 | A grant is open |
| xfer_line | output | 4 | Index of the granted line |
| xfer_count | output | 5 | Beats to move for the grant |
| xfer_last | output | 1 | The grant ends a packet |
| clr | output | 16 | Per-line clear/acknowledge pulse |

## Verification
The assertions assume the following about the inputs. Reset is applied before any request. `burst_size` is steady for a line while that line is pending. A peripheral holds its request until it sees its clear pulse, and `xfer_done` pulses at most once per cycle. The stimulus drives every input on the falling clock edge and keeps each request set asserted until the clear arrives. It then drops every request and drains any lower-priority grants before the next vector, so each vector starts from an idle unit with no line locked out.

// File: rtl/dma_req_handshake.sv
module dma_req_handshake #(
  parameter int NLINES = 16,
  localparam int LW = $clog2(NLINES),
  localparam int CW = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NLINES-1:0]   burst_req,
  input  logic [NLINES-1:0]   single_req,
  input  logic [NLINES-1:0]   last_burst_req,
  input  logic [NLINES-1:0]   last_single_req,
  input  logic [2*NLINES-1:0] burst_size,
  input  logic                xfer_done,
  output logic                xfer_valid,
  output logic [LW-1:0]       xfer_line,
  output logic [CW-1:0]       xfer_count,
  output logic                xfer_last,
  output logic [NLINES-1:0]   clr
);

  logic [NLINES-1:0] b_m, b_s, s_m, s_s, lb_m, lb_s, ls_m, ls_s;
  logic [NLINES-1:0] lock, any_s, pend, line_oh, fin_oh;
  logic [LW-1:0]     sel;
  logic [CW-1:0]     left, grant_cnt;
  logic              grant_last, wide, finish;
  logic [1:0]        code;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_m <= '0; b_s <= '0; s_m <= '0; s_s <= '0;
      lb_m <= '0; lb_s <= '0; ls_m <= '0; ls_s <= '0;
    end else begin
      b_m  <= burst_req;       b_s  <= b_m;
      s_m  <= single_req;      s_s  <= s_m;
      lb_m <= last_burst_req;  lb_s <= lb_m;
      ls_m <= last_single_req; ls_s <= ls_m;
    end
  end

  assign any_s = b_s | s_s | lb_s | ls_s;
  assign pend  = any_s & ~lock;

  always_comb begin
    sel = '0;
    for (int i = NLINES - 1; i >= 0; i--)
      if (pend[i]) sel = LW'(i);
  end

  assign wide = b_s[sel] | lb_s[sel];
  assign code = burst_size[2*sel +: 2];

  always_comb begin
    if (!wide) grant_cnt = CW'(1);
    else case (code)
      2'd0:    grant_cnt = CW'(1);
      2'd1:    grant_cnt = CW'(4);
      2'd2:    grant_cnt = CW'(8);
      default: grant_cnt = CW'(16);
    endcase
  end

  assign grant_last = wide ? lb_s[sel] : ls_s[sel];
  assign line_oh    = NLINES'(1) << xfer_line;
  assign finish     = xfer_valid && xfer_done && (left == CW'(1));
  assign fin_oh     = finish ? line_oh : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xfer_valid <= 1'b0;
      xfer_line  <= '0;
      xfer_count <= '0;
      xfer_last  <= 1'b0;
      left       <= '0;
      clr        <= '0;
      lock       <= '0;
    end else begin
      clr  <= fin_oh;
      lock <= (lock & any_s) | fin_oh;
      if (!xfer_valid) begin
        if (|pend) begin
          xfer_valid <= 1'b1;
          xfer_line  <= sel;
          xfer_count <= grant_cnt;
          left       <= grant_cnt;
          xfer_last  <= grant_last;
        end
      end else if (xfer_done) begin
        if (left == CW'(1)) xfer_valid <= 1'b0;
        else left <= left - CW'(1);
      end
    end
  end

  p_clr_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr));
  p_clr_single_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0) |=> (clr == '0));
  p_clr_needs_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0) |-> ($past(xfer_done) && $past(xfer_valid) && !xfer_valid));
  p_count_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> (xfer_count == 1 || xfer_count == 4 || xfer_count == 8 || xfer_count == 16));
  p_grant_unlocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !$past(xfer_valid)) |-> (($past(lock) & line_oh) == '0));
  p_hold_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !finish) |=> (xfer_valid && $stable(xfer_line) && $stable(xfer_count) && $stable(xfer_last)));

endmodule

// File: tb/dma_req_handshake_tb.sv
module dma_req_handshake_tb;
  localparam int N = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] burst_req = '0, single_req = '0, last_burst_req = '0, last_single_req = '0;
  logic [2*N-1:0] burst_size = '0;
  logic xfer_done = 1'b0;
  logic xfer_valid, xfer_last;
  logic [3:0] xfer_line;
  logic [4:0] xfer_count;
  logic [N-1:0] clr;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dma_req_handshake u_dut (
    .clk(clk), .rst_n(rst_n),
    .burst_req(burst_req), .single_req(single_req),
    .last_burst_req(last_burst_req), .last_single_req(last_single_req),
    .burst_size(burst_size), .xfer_done(xfer_done),
    .xfer_valid(xfer_valid), .xfer_line(xfer_line), .xfer_count(xfer_count),
    .xfer_last(xfer_last), .clr(clr)
  );

  typedef struct packed {
    logic [15:0] b, s, lb, ls;
    logic [31:0] sz;
    logic [3:0]  line;
    logic [4:0]  cnt;
    logic        last;
  } vec_t;

  localparam vec_t VEC [0:7] = '{
    '{b:16'h0000, s:16'h0008, lb:16'h0000, ls:16'h0000, sz:32'h0,      line:4'd3,  cnt:5'd1,  last:1'b0},
    '{b:16'h0004, s:16'h0000, lb:16'h0000, ls:16'h0000, sz:32'h10,     line:4'd2,  cnt:5'd4,  last:1'b0},
    '{b:16'h0080, s:16'h0080, lb:16'h0000, ls:16'h0000, sz:32'h8000,   line:4'd7,  cnt:5'd8,  last:1'b0},
    '{b:16'h0000, s:16'h0000, lb:16'h0001, ls:16'h0000, sz:32'h3,      line:4'd0,  cnt:5'd16, last:1'b1},
    '{b:16'h0000, s:16'h1000, lb:16'h0000, ls:16'h0200, sz:32'h0,      line:4'd9,  cnt:5'd1,  last:1'b1},
    '{b:16'h8000, s:16'h0400, lb:16'h0000, ls:16'h0000, sz:32'h0,      line:4'd10, cnt:5'd1,  last:1'b0},
    '{b:16'h0010, s:16'h0000, lb:16'h0000, ls:16'h0010, sz:32'h100,    line:4'd4,  cnt:5'd4,  last:1'b0},
    '{b:16'h0002, s:16'h0000, lb:16'h0002, ls:16'h0000, sz:32'hC,      line:4'd1,  cnt:5'd16, last:1'b1}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drop_and_drain();
    burst_req = '0; single_req = '0; last_burst_req = '0; last_single_req = '0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      xfer_done = xfer_valid;
    end
    xfer_done = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_beats(int n, logic [3:0] line);
    for (int k = 0; k < n; k++) begin
      xfer_done = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0;
      if (k < n - 1) begin
        check("R8 no early clr", 32'(clr), 32'h0);
        check("R11 line held", 32'(xfer_line), 32'(line));
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 valid after reset", 32'(xfer_valid), 32'h0);
    check("R10 clr after reset", 32'(clr), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: done while idle is ignored
    repeat (3) begin xfer_done = 1'b1; @(negedge clk); end
    xfer_done = 1'b0;
    check("R8 idle done clr", 32'(clr), 32'h0);
    check("R8 idle done valid", 32'(xfer_valid), 32'h0);

    for (int v = 0; v < 8; v++) begin
      burst_req = VEC[v].b; single_req = VEC[v].s;
      last_burst_req = VEC[v].lb; last_single_req = VEC[v].ls;
      burst_size = VEC[v].sz;
      repeat (2) @(negedge clk);
      check("R1 not yet valid", 32'(xfer_valid), 32'h0);
      @(negedge clk);
      check("R1 valid on third edge", 32'(xfer_valid), 32'h1);
      check("R2 granted line", 32'(xfer_line), 32'(VEC[v].line));
      check("R3 R4 R5 count", 32'(xfer_count), 32'(VEC[v].cnt));
      check("R6 last flag", 32'(xfer_last), 32'(VEC[v].last));
      run_beats(int'(VEC[v].cnt), VEC[v].line);
      check("R7 clr pulse", 32'(clr), 32'h1 << VEC[v].line);
      check("R7 valid falls", 32'(xfer_valid), 32'h0);
      @(negedge clk);
      check("R7 clr one cycle", 32'(clr), 32'h0);
      drop_and_drain();
    end

    // R9: a held request is not serviced twice
    single_req = 16'h0040;
    repeat (3) @(negedge clk);
    check("R9 first grant", 32'(xfer_valid), 32'h1);
    run_beats(1, 4'd6);
    check("R9 clr", 32'(clr), 32'h40);
    repeat (10) @(negedge clk);
    check("R9 held line locked", 32'(xfer_valid), 32'h0);
    single_req = '0;
    repeat (4) @(negedge clk);
    check("R9 still idle after drop", 32'(xfer_valid), 32'h0);
    single_req = 16'h0040;
    repeat (3) @(negedge clk);
    check("R9 regrant after release", 32'(xfer_valid), 32'h1);
    check("R9 regrant line", 32'(xfer_line), 32'd6);
    run_beats(1, 4'd6);
    drop_and_drain();

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1600000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule